// File: doc/BRIEF.md
# Self-Routing Butterfly Switch Network

This block moves single-flit packets between sixteen endpoints through a multistage butterfly made of two-by-two switching elements. There are log2 N stages of N/2 elements each. Each element decides alone whether to pass a packet straight through or across. It takes that decision from one bit of the routing tag, which is the exclusive OR of the source and destination addresses. No central controller sets up paths, and every packet crosses every stage.

Each input port offers a packet with a valid/ready handshake. The packet carries a destination address and a payload, and the network stamps the port index onto it as its source address. Every stage is registered, so a packet that meets no resistance reaches its output port a fixed number of cycles after it is accepted. Only one path joins any source to any destination, so two packets inside one element can want the same output. A round-robin arbiter in that element picks one of them. The other packet waits in its stage register, and ready is withdrawn up the chain. Output ports present a valid strobe only and never push back.

Top module: `bfly_net`

## Requirements
- R1: While reset is asserted, and after it with no input valid, every out_valid bit and every in_ready bit is low.
- R2: A packet leaves on the output port equal to its destination address. Its out_data equals the payload it entered with, and its out_src equals the index of the input port that accepted it.
- R3: A packet accepted in cycle c, with no contention on its path, shows out_valid in cycle c+4 (log2 N) and not earlier.
- R4: At stage s, which pairs lines differing only in address bit s, a packet goes straight when bit s of source XOR destination is 0 and crosses when it is 1. After stage s, bits 0..s of its line equal its destination and the higher bits equal its source.
- R5: When all sixteen ports offer packets in the same cycle with destination = source XOR k, for any constant k from 0 to 15 (k = 0 is the identity), all sixteen are accepted in that cycle.
- R6: When two packets want the same element output, exactly one moves forward. The loser stays in place, in_ready stays low for it while it waits, and no packet is ever lost or duplicated.
- R7: Each element's arbiter favours its lower-indexed line after reset and passes the favour to the other line each time it settles a contested grant.
- R8: Packets from one source to one destination leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| in_valid | input | N | Per-port packet offered |
| in_ready | output | N | Per-port packet accepted this cycle |
| in_dst | input | N*AW | Per-port destination address, port p at bits p*AW upward |
| in_data | input | N*W | Per-port payload, port p at bits p*W upward |
| out_valid | output | N | Per-port packet delivered this cycle |
| out_src | output | N*AW | Source address of the delivered packet |
| out_data | output | N*W | Payload of the delivered packet |

## Verification
in_ready is a combinational answer to the current in_valid and the state of the network. The bench therefore reads it in the same cycle in which it drives the offer, and it reads it between clock edges, after driving inputs just past the rising edge. Delivery is due four cycles after acceptance. In the permutation waves the bench reads the outputs on the three cycles in between, expecting them quiet, and then on the fourth, expecting all sixteen. The arbitration checks read in_ready on consecutive contested cycles. Under random traffic, delayed delivery is allowed, so every output is checked for destination and per-pair sequence whenever it is valid, and the totals are compared after a drain.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  typedef enum logic {SET_STRAIGHT = 1'b0, SET_CROSS = 1'b1} sw_set_e;

  // Element setting for address bit idx, taken from the source/destination tag.
  function automatic sw_set_e route_set(input logic [7:0] src,
                                        input logic [7:0] dst,
                                        input int unsigned idx);
    return (src[idx] ^ dst[idx]) ? SET_CROSS : SET_STRAIGHT;
  endfunction

endpackage

// File: rtl/bfly_arb.sv
module bfly_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       adv,
  output logic [1:0] gnt
);
  logic pri_q, pri_d;

  always_comb begin
    gnt   = req;
    pri_d = pri_q;
    if (&req) begin
      gnt = pri_q ? 2'b10 : 2'b01;
      if (adv) pri_d = ~pri_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pri_q <= 1'b0;
    else        pri_q <= pri_d;
  end
endmodule

// File: rtl/bfly_switch.sv
module bfly_switch
  import bfly_pkg::*;
#(
  parameter int AW = 4,
  parameter int W  = 16,
  parameter int S  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          in_v,
  input  logic [1:0][AW-1:0]  in_dst,
  input  logic [1:0][AW-1:0]  in_src,
  input  logic [1:0][W-1:0]   in_data,
  output logic [1:0]          in_take,
  input  logic [1:0]          out_take,
  output logic [1:0]          q_v,
  output logic [1:0][AW-1:0]  q_dst,
  output logic [1:0][AW-1:0]  q_src,
  output logic [1:0][W-1:0]   q_data
);
  sw_set_e              set_lo, set_hi;
  logic [1:0]           want;
  logic [1:0][1:0]      req, gnt;
  logic [1:0]           free, load, pick, d_v;
  logic [1:0][AW-1:0]   d_dst, d_src;
  logic [1:0][W-1:0]    d_data;

  assign set_lo  = route_set(8'(in_src[0]), 8'(in_dst[0]), S);
  assign set_hi  = route_set(8'(in_src[1]), 8'(in_dst[1]), S);
  assign want[0] = (set_lo == SET_CROSS);
  assign want[1] = (set_hi == SET_STRAIGHT);
  assign free    = ~q_v | out_take;

  for (genvar o = 0; o < 2; o++) begin : g_out
    for (genvar x = 0; x < 2; x++) begin : g_req
      assign req[o][x] = in_v[x] && (want[x] == 1'(o));
    end
    bfly_arb u_arb (
      .clk (clk),
      .rst_n (rst_n),
      .req (req[o]),
      .adv (free[o]),
      .gnt (gnt[o])
    );
    assign load[o] = (|req[o]) && free[o];
    assign pick[o] = gnt[o][1];
  end

  for (genvar x = 0; x < 2; x++) begin : g_take
    assign in_take[x] = in_v[x] && free[want[x]] && gnt[want[x]][x];
  end

  always_comb begin
    for (int o = 0; o < 2; o++) begin
      d_v[o]    = q_v[o] & ~out_take[o];
      d_dst[o]  = q_dst[o];
      d_src[o]  = q_src[o];
      d_data[o] = q_data[o];
      if (load[o]) begin
        d_v[o]    = 1'b1;
        d_dst[o]  = in_dst[pick[o]];
        d_src[o]  = in_src[pick[o]];
        d_data[o] = in_data[pick[o]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_v <= '0;
    else        q_v <= d_v;
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < 2; o++) begin
      if (load[o]) begin
        q_dst[o]  <= d_dst[o];
        q_src[o]  <= d_src[o];
        q_data[o] <= d_data[o];
      end
    end
  end
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
  parameter int N  = 16,
  parameter int AW = 4,
  parameter int W  = 16,
  parameter int S  = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              up_v,
  input  logic [N-1:0][AW-1:0]      up_dst,
  input  logic [N-1:0][AW-1:0]      up_src,
  input  logic [N-1:0][W-1:0]       up_data,
  output logic [N-1:0]              up_take,
  input  logic [N-1:0]              dn_take,
  output logic [N-1:0]              q_v,
  output logic [N-1:0][AW-1:0]      q_dst,
  output logic [N-1:0][AW-1:0]      q_src,
  output logic [N-1:0][W-1:0]       q_data
);
  localparam int PAIRS = N / 2;

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    localparam int LO = ((j >> S) << (S + 1)) | (j & ((1 << S) - 1));
    localparam int HI = LO + (1 << S);

    logic [1:0]         e_take, e_v;
    logic [1:0][AW-1:0] e_dst, e_src;
    logic [1:0][W-1:0]  e_data;

    bfly_switch #(.AW(AW), .W(W), .S(S)) u_sw (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     ({up_v[HI], up_v[LO]}),
      .in_dst   ({up_dst[HI], up_dst[LO]}),
      .in_src   ({up_src[HI], up_src[LO]}),
      .in_data  ({up_data[HI], up_data[LO]}),
      .in_take  (e_take),
      .out_take ({dn_take[HI], dn_take[LO]}),
      .q_v      (e_v),
      .q_dst    (e_dst),
      .q_src    (e_src),
      .q_data   (e_data)
    );

    assign up_take[LO] = e_take[0];
    assign up_take[HI] = e_take[1];
    assign q_v[LO]     = e_v[0];
    assign q_v[HI]     = e_v[1];
    assign q_dst[LO]   = e_dst[0];
    assign q_dst[HI]   = e_dst[1];
    assign q_src[LO]   = e_src[0];
    assign q_src[HI]   = e_src[1];
    assign q_data[LO]  = e_data[0];
    assign q_data[HI]  = e_data[1];
  end
endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  output logic [N-1:0]    in_ready,
  input  logic [N*AW-1:0] in_dst,
  input  logic [N*W-1:0]  in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*AW-1:0] out_src,
  output logic [N*W-1:0]  out_data
);
  localparam int LOG = AW;

  logic [LOG-1:0][N-1:0]          sv, stake, dtake;
  logic [LOG-1:0][N-1:0][AW-1:0]  sdst, ssrc;
  logic [LOG-1:0][N-1:0][W-1:0]   sdata;
  logic [N-1:0][AW-1:0]           port_id, port_dst;
  logic [N-1:0][W-1:0]            port_data;

  assign port_dst  = in_dst;
  assign port_data = in_data;

  for (genvar p = 0; p < N; p++) begin : g_id
    assign port_id[p] = AW'(p);
  end

  for (genvar s = 0; s < LOG; s++) begin : g_stage
    if (s == LOG - 1) begin : g_last
      assign dtake[s] = '1;
    end else begin : g_mid
      assign dtake[s] = stake[s+1];
    end

    if (s == 0) begin : g_first
      bfly_stage #(.N(N), .AW(AW), .W(W), .S(s)) u_stage (
        .clk (clk), .rst_n (rst_n),
        .up_v (in_valid), .up_dst (port_dst), .up_src (port_id), .up_data (port_data),
        .up_take (stake[s]), .dn_take (dtake[s]),
        .q_v (sv[s]), .q_dst (sdst[s]), .q_src (ssrc[s]), .q_data (sdata[s])
      );
    end else begin : g_next
      bfly_stage #(.N(N), .AW(AW), .W(W), .S(s)) u_stage (
        .clk (clk), .rst_n (rst_n),
        .up_v (sv[s-1]), .up_dst (sdst[s-1]), .up_src (ssrc[s-1]), .up_data (sdata[s-1]),
        .up_take (stake[s]), .dn_take (dtake[s]),
        .q_v (sv[s]), .q_dst (sdst[s]), .q_src (ssrc[s]), .q_data (sdata[s])
      );
    end
  end

  assign in_ready  = stake[0];
  assign out_valid = sv[LOG-1];
  assign out_src   = ssrc[LOG-1];
  assign out_data  = sdata[LOG-1];
endmodule

// File: rtl/bfly_net_chk.sv
module bfly_net_chk #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int AW = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [N-1:0]                  in_valid,
  input logic [N-1:0]                  in_ready,
  input logic [N*AW-1:0]               in_dst,
  input logic [AW-1:0][N-1:0]          sv,
  input logic [AW-1:0][N-1:0]          dtake,
  input logic [AW-1:0][N-1:0][AW-1:0]  sdst,
  input logic [AW-1:0][N-1:0][AW-1:0]  ssrc,
  input logic [AW-1:0][N-1:0][W-1:0]   sdata
);
  for (genvar s = 0; s < AW; s++) begin : g_s
    localparam logic [AW-1:0] LM = AW'((1 << (s + 1)) - 1);
    for (genvar l = 0; l < N; l++) begin : g_l
      // R4: settled address bits follow the destination.
      p_route_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sv[s][l] |-> (((sdst[s][l] ^ AW'(l)) & LM) == '0));
      // R4: unsettled address bits still follow the source.
      p_route_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sv[s][l] |-> (((ssrc[s][l] ^ AW'(l)) & ~LM) == '0));
      // R6: a packet not taken downstream stays put.
      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sv[s][l] && !dtake[s][l]) |=> (sv[s][l] && $stable(sdata[s][l]) && $stable(sdst[s][l])));
    end
  end

  for (genvar a = 0; a < N / 2; a++) begin : g_pair0
    // R6: two first-stage offers bound for the same element output are never both taken.
    p_no_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[2*a] && in_valid[2*a+1] && (in_dst[(2*a)*AW] == in_dst[(2*a+1)*AW]))
        |-> !(in_ready[2*a] && in_ready[2*a+1]));
  end
endmodule

bind bfly_net bfly_net_chk #(.N(N), .W(W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_dst   (in_dst),
  .sv       (sv),
  .dtake    (dtake),
  .sdst     (sdst),
  .ssrc     (ssrc),
  .sdata    (sdata)
);

// File: tb/bfly_net_test.sv
`timescale 1ns/100ps
module bfly_net_test;
  localparam int N = 16;
  localparam int W = 16;
  localparam int AW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    vin = '0;
  logic [N-1:0]    in_ready;
  logic [N*AW-1:0] in_dst_f;
  logic [N*W-1:0]  in_data_f;
  logic [N-1:0]    out_valid;
  logic [N*AW-1:0] out_src;
  logic [N*W-1:0]  out_data;

  logic [AW-1:0] pd [N];
  logic [W-1:0]  pp [N];
  int send_seq [N][N];
  int recv_seq [N][N];
  int nchk = 0, nfail = 0, sent = 0, recvd = 0;
  logic [N-1:0] acc, last_outv;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < N; p++) begin
      in_dst_f[p*AW +: AW] = pd[p];
      in_data_f[p*W +: W]  = pp[p];
    end
  end

  bfly_net #(.N(N), .W(W)) uut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (vin), .in_ready (in_ready),
    .in_dst (in_dst_f), .in_data (in_data_f),
    .out_valid (out_valid), .out_src (out_src), .out_data (out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int p, input int d);
    pd[p]  = AW'(d);
    pp[p]  = {AW'(d), 12'(send_seq[p][d])};
    send_seq[p][d]++;
    vin[p] = 1'b1;
    sent++;
  endtask

  // One cycle: observe between edges, then advance past the rising edge.
  task automatic step();
    @(negedge clk);
    acc = vin & in_ready;
    last_outv = out_valid;
    for (int o = 0; o < N; o++) begin
      if (out_valid[o]) begin
        int s;
        logic [W-1:0] dat;
        s   = int'(out_src[o*AW +: AW]);
        dat = out_data[o*W +: W];
        chk(int'(dat[15:12]) == o, "R2 output port matches destination", int'(dat[15:12]), o);
        chk(dat[11:0] == 12'(recv_seq[s][o]), "R8 per-pair order", int'(dat[11:0]), recv_seq[s][o]);
        recv_seq[s][o]++;
        recvd++;
      end
    end
    @(posedge clk);
    #1;
    vin = vin & ~acc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < N; p++) begin
      pd[p] = '0;
      pp[p] = '0;
      for (int d = 0; d < N; d++) begin
        send_seq[p][d] = 0;
        recv_seq[p][d] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '0, "R1 in_ready idle", int'(in_ready), 0);
    @(posedge clk);
    #1;

    // R7: contested first-stage output, favour alternates.
    put(0, 0); put(1, 0);
    step();
    chk(acc[1:0] == 2'b01, "R7 lower line wins first", int'(acc[1:0]), 1);
    put(0, 0);
    step();
    chk(acc[1:0] == 2'b10, "R7 favour passes to upper line", int'(acc[1:0]), 2);
    chk(vin[1] == 1'b0, "R6 held packet later accepted", int'(vin[1]), 0);
    put(1, 0);
    step();
    chk(acc[1:0] == 2'b01, "R7 favour returns to lower line", int'(acc[1:0]), 1);
    while (vin != '0) step();
    repeat (6) step();

    // R5 and R3: identity (k=0) and every bit-complement permutation.
    for (int k = 0; k < N; k++) begin
      for (int p = 0; p < N; p++) put(p, p ^ k);
      step();
      chk(acc == '1, "R5 permutation fully accepted", int'(acc), 16'hFFFF);
      for (int c = 0; c < 3; c++) begin
        step();
        chk(last_outv == '0, "R3 no early delivery", int'(last_outv), 0);
      end
      step();
      chk(last_outv == '1, "R3 delivery after four cycles", int'(last_outv), 16'hFFFF);
      step();
    end

    // R6, R8, R2: random traffic with contention.
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < N; p++)
        if (!vin[p] && ($urandom % 2 == 0)) put(p, int'($urandom % N));
      step();
    end
    for (int c = 0; c < 400 && vin != '0; c++) step();
    repeat (8) step();
    chk(recvd == sent, "R6 nothing lost or duplicated", recvd, sent);
    chk(out_valid == '0, "R6 network drained", int'(out_valid), 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule